// File: doc/BRIEF.md
# Circular Address Register Update Unit

This block works out the next value of a 16-bit address register that steps through a circular buffer. A companion wrap value sets the buffer length, and the block turns it into a power-of-two-minus-one mask. A signed step is added to the current address or subtracted from it. When the masked low bits of the address and step cross the mask boundary, the result is folded back by wrap+1. The whole decision is made in one pass. The address is not moved one unit at a time, so the cost is the same for a step of any size.

The caller presents the current address, the wrap value, the step and a 2-bit operation code. The new address comes out combinationally on `next_addr`. A registered copy appears on `next_addr_q` after the next rising clock edge when the `REG_OUT` parameter is 1, which is the default. Selecting among several address/wrap/step register sets is left to the surrounding core.

Top module: `car_addr_update`

## Requirements
- R1: The internal mask is the smallest all-ones value that is greater than or equal to the wrap value, with bit 0 forced to 1. A wrap of 0 gives mask 1, a wrap of 4 gives mask 7, and a wrap of 0xFFFF gives mask 0xFFFF.
- R2: Op code 2'b00 (add step) with a step of 0 or more gives address+step. If (address & mask) + (step & mask) − mask − 1 is 0 or more, wrap+1 is then subtracted. Example: wrap 5, address 0x27, step 1 gives 0x22.
- R3: Op code 2'b00 with a negative step gives address+step. If (address & mask) + (step & mask) − mask − 1 is less than mask − wrap, wrap+1 is then added. Example: wrap 7, address 0x12, step −3 gives 0x17.
- R4: Op code 2'b01 (subtract step) uses the adjusted step a = −step−1, taken as a 16-bit signed value. It gives address − step. When a ≥ 1, wrap+1 is subtracted if (address & mask) + (a & mask) − mask ≥ 0. Otherwise wrap+1 is added if that sum is less than mask − wrap. Example: wrap 7, address 0x16, step −3 gives 0x11.
- R5: Op code 2'b10 gives the same result as op 2'b00 with step 1, and op code 2'b11 gives the same result as op 2'b01 with step 1. For both codes the step input has no effect. Examples: wrap 7, address 0x17, op 2'b10 gives 0x10; wrap 7, address 0x10, op 2'b11 gives 0x17.
- R6: A wrap value of 0xFFFF gives plain 16-bit addition and subtraction that roll over naturally. For example, 0xFFFF + 1 gives 0x0000.
- R7: `next_addr` settles in the same cycle as its inputs. `next_addr_q` holds 0 while `rst_n` is low, and after each rising edge it equals the `next_addr` that was present before that edge.
- R8: Only the masked low bits decide the correction, and at most one correction of ±(wrap+1) is applied, even for steps longer than the buffer. The result is kept modulo 2^16. Example: wrap 7, address 0x10, step 20 gives 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output |
| rst_n | input | 1 | Active-low reset of the registered output |
| cur_addr | input | 16 | Current address register value |
| wrap_len | input | 16 | Wrap value (buffer length minus one) |
| step | input | 16 | Signed step, two's complement |
| op | input | 2 | 00 add step, 01 subtract step, 10 plus one, 11 minus one |
| next_addr | output | 16 | Updated address, combinational |
| next_addr_q | output | 16 | Updated address, registered one clock later |

## Verification
The combinational result is due as soon as the inputs settle. The bench drives each vector on a falling edge and compares `next_addr` 2 ns later, inside the same cycle. The registered result is due one rising edge later. The bench waits for that edge and compares `next_addr_q` 2 ns after it, while the inputs are still held, so both comparisons refer to the same vector.

// File: rtl/car_pkg.sv
package car_pkg;
    typedef enum logic [1:0] {
        CAR_ADD = 2'b00,
        CAR_SUB = 2'b01,
        CAR_INC = 2'b10,
        CAR_DEC = 2'b11
    } car_op_e;
endpackage

// File: rtl/car_mask_gen.sv
// Smallest all-ones cover of the wrap value, bit 0 forced high.
module car_mask_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] mask
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] smear [0:STAGES];

    assign smear[0] = wrap_val;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_smear
            assign smear[k+1] = smear[k] | (smear[k] >> (1 << k));
        end
    endgenerate

    assign mask = smear[STAGES] | W'(1);
endmodule

// File: rtl/car_operand_sel.sv
// Maps the operation code to an operand and a carry-in for the wrap core.
module car_operand_sel #(
    parameter int W = 16
) (
    input  logic [1:0]   op_code,
    input  logic [W-1:0] step_in,
    output logic [W-1:0] oper,
    output logic         cin
);
    import car_pkg::*;

    car_op_e opv;

    always_comb begin
        opv = car_op_e'(op_code);
        unique case (opv)
            CAR_ADD: begin oper = step_in;   cin = 1'b0; end
            CAR_SUB: begin oper = ~step_in;  cin = 1'b1; end
            CAR_INC: begin oper = W'(1);     cin = 1'b0; end
            CAR_DEC: begin oper = ~W'(1);    cin = 1'b1; end
        endcase
    end
endmodule

// File: rtl/car_wrap_core.sv
// One-pass wrapped add: raw = cur + oper + cin, corrected once by wrap+1.
module car_wrap_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wrap_val,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] oper,
    input  logic         cin,
    output logic [W-1:0] nxt
);
    localparam int CW = W + 3;

    logic signed [CW-1:0] am, om, mm, thr, cmp, dirv;
    logic                 fwd, do_sub, do_add;
    logic [W-1:0]         raw, corr;

    always_comb begin
        am   = {3'b000, cur & mask};
        om   = {3'b000, oper & mask};
        mm   = {3'b000, mask};
        thr  = mm - {3'b000, wrap_val};
        cmp  = am + om - mm - CW'(1) + CW'(cin);
        dirv = {{3{oper[W-1]}}, oper} - CW'(cin);
        fwd    = ~dirv[CW-1];
        do_sub = fwd & ~cmp[CW-1];
        do_add = ~fwd & (cmp < thr);
        raw  = cur + oper + W'(cin);
        corr = wrap_val + W'(1);
        if (do_sub)
            nxt = raw - corr;
        else if (do_add)
            nxt = raw + corr;
        else
            nxt = raw;
    end
endmodule

// File: rtl/car_addr_update.sv
module car_addr_update #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  cur_addr,
    input  logic [15:0]  wrap_len,
    input  logic [15:0]  step,
    input  logic [1:0]   op,
    output logic [15:0]  next_addr,
    output logic [15:0]  next_addr_q
);
    logic [W-1:0] wr_mask;
    logic [W-1:0] oper;
    logic         cin;

    car_mask_gen #(.W(W)) u_mask (
        .wrap_val (wrap_len),
        .mask     (wr_mask)
    );

    car_operand_sel #(.W(W)) u_opsel (
        .op_code (op),
        .step_in (step),
        .oper    (oper),
        .cin     (cin)
    );

    car_wrap_core #(.W(W)) u_core (
        .cur      (cur_addr),
        .wrap_val (wrap_len),
        .mask     (wr_mask),
        .oper     (oper),
        .cin      (cin),
        .nxt      (next_addr)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q_r <= '0;
                else
                    q_r <= next_addr;
            end
            assign next_addr_q = q_r;

            // R7
            reg_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> next_addr_q == $past(next_addr));
        end else begin : g_comb
            assign next_addr_q = next_addr;
        end
    endgenerate

    // R1
    mask_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_mask & wrap_len) == wrap_len) && wr_mask[0]);

    // R1
    mask_tight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask >> 1) < (wrap_len | W'(1)));

    // R6
    linear_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_len == '1 && op == 2'b00) |-> next_addr == W'(cur_addr + step));

    // R6
    linear_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_len == '1 && op == 2'b01) |-> next_addr == W'(cur_addr - step));

    // R5
    inc_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_len == '1 && op == 2'b10) |-> next_addr == W'(cur_addr + W'(1)));
endmodule

// File: tb/sim_car_addr_update.sv
module sim_car_addr_update;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cur_addr = '0;
    logic [15:0] wrap_len = '0;
    logic [15:0] step = '0;
    logic [1:0]  op = '0;
    logic [15:0] next_addr, next_addr_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    car_addr_update u0 (
        .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .wrap_len(wrap_len),
        .step(step), .op(op), .next_addr(next_addr), .next_addr_q(next_addr_q)
    );

    function automatic int calc_mask(int wr);
        int m = 1;
        while (m < wr) m = (m << 1) | 1;
        return m;
    endfunction

    // Expected value straight from R2..R5 arithmetic
    function automatic int exp_next(int ar, int wr, int st, int opc);
        int m = calc_mask(wr);
        int ix = st;
        int nar, c, j;
        bit sub = (opc == 1) || (opc == 3);
        if (opc >= 2) ix = 1;
        if (!sub) begin
            nar = ar + ix;
            c = (ar & m) + (ix & m) - m - 1;
            if (ix >= 0) begin
                if (c >= 0) nar -= wr + 1;
            end else if (c < m - wr) nar += wr + 1;
        end else begin
            j = -ix - 1;
            if (j > 32767) j -= 65536;
            nar = ar + j + 1;
            c = (ar & m) + (j & m) - m;
            if (j - 1 >= 0) begin
                if (c >= 0) nar -= wr + 1;
            end else if (c < m - wr) nar += wr + 1;
        end
        return nar & 16'hFFFF;
    endfunction

    task automatic chk(string tag, int got, int expv);
        checks++;
        if (got != expv) begin
            failures++;
            $display("FAIL %s got=%04h exp=%04h", tag, got, expv);
        end
    endtask

    task automatic apply(string tag, int ar, int wr, int st, int opc, int expv);
        @(negedge clk);
        cur_addr = ar[15:0]; wrap_len = wr[15:0]; step = st[15:0]; op = opc[1:0];
        #2 chk(tag, int'(next_addr), expv);
        @(posedge clk);
        #2 chk({tag, "/R7"}, int'(next_addr_q), expv);
    endtask

    task automatic sweep(string tag, int ar, int wr, int st, int opc);
        apply(tag, ar, wr, st, opc, exp_next(ar, wr, st, opc));
    endtask

    initial begin
        int wraps [17] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 13, 31, 100, 'h3FF, 'h1234, 'h7FFF, 'h8000, 'hFFFF};
        int unsigned seed = 32'h1ACE_0001;
        repeat (3) @(posedge clk);
        #2 chk("R7 reset", int'(next_addr_q), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Hand-computed corners
        apply("R2 wrap-at-top", 'h27, 5, 1, 0, 'h22);
        apply("R2 no-wrap", 'h25, 5, 1, 0, 'h26);
        apply("R3 neg-step", 'h12, 7, -3, 0, 'h17);
        apply("R4 sub-neg", 'h16, 7, -3, 1, 'h11);
        apply("R4 sub-pos", 'h22, 5, 1, 1, 'h27);
        apply("R5 inc", 'h17, 7, 'h1234, 2, 'h10);
        apply("R5 dec", 'h10, 7, -'h55, 3, 'h17);
        apply("R6 rollover", 'hFFFF, 'hFFFF, 1, 0, 0);
        apply("R6 sub-roll", 0, 'hFFFF, 1, 1, 'hFFFF);
        apply("R8 long-step", 'h10, 7, 20, 0, 'h24);
        apply("R1 wrap0", 'h40, 0, 1, 0, 'h41);
        apply("R1 wrap0-odd", 'h41, 0, 1, 0, 'h41);

        foreach (wraps[w]) begin
            for (int a = 0; a < 12; a++) begin
                int ar, wr;
                int steps [22];
                seed = seed * 32'd1103515245 + 32'd12345;
                ar = int'(seed[23:8]);
                wr = wraps[w];
                for (int s = 0; s < 14; s++) steps[s] = -20 + 3 * s;
                steps[14] = 'h40;   steps[15] = -'h40;
                steps[16] = wr;     steps[17] = -wr;
                steps[18] = wr + 1; steps[19] = -(wr + 1);
                steps[20] = 'h7FFF; steps[21] = -'h8000;
                for (int s = 0; s < 22; s++) begin
                    int st = steps[s];
                    if (st > 32767) st -= 65536;
                    if (st < -32768) st += 65536;
                    for (int o = 0; o < 2; o++) begin
                        string tg;
                        if (wr == 'hFFFF) tg = "R6 sweep";
                        else if (st > wr + 1 || -st > wr + 1) tg = "R8 sweep";
                        else if (o == 1) tg = "R4 sweep";
                        else if (st >= 0) tg = "R2 sweep";
                        else tg = "R3 sweep";
                        sweep(tg, ar, wr, st, o);
                    end
                end
                sweep("R5 sweep-inc", ar, wr, int'(seed[15:0]), 2);
                sweep("R5 sweep-dec", ar, wr, int'(seed[15:0]), 3);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule